// File: doc/BRIEF.md
# Ping-Pong Stream-to-Memory Writer

The block takes a valid/ready sample stream and stores it word by word into a synchronous memory, alternating between two fixed-length buffers. While one buffer fills, software can work on the other. A small FIFO sits between the stream input and the memory writer. It soaks up the cycles in which the writer has to wait, for example when the next buffer has not yet been handed back by software.

Each buffer has a base address, a length, a hardware-ownership bit and a park bit. The writer only writes into a buffer that hardware owns. When the last word of a buffer is written, the block does four things:
- it switches to the other buffer;
- it raises a pending flag that drives the interrupt;
- it records which buffer completed;
- it advances a completion counter.

Software can therefore always tell which buffer is full, and it can detect a missed interrupt from the counter or from a sticky overrun flag. In park mode ownership is kept on completion, so the two buffers cycle with no software action. Without park mode ownership is dropped on completion, and software re-arms the buffer.

Register port (3-bit word address, write strobe, read data taken combinationally from the address):

| Addr | Contents |
|---|---|
| 0 | bit0 interrupt enable |
| 1 | base of buffer 0 |
| 2 | length of buffer 0 |
| 3 | base of buffer 1 |
| 4 | length of buffer 1 |
| 5 | arm: writing 1 to bit i sets ownership of buffer i; reads return both ownership bits |
| 6 | park bits [1:0], one per buffer |
| 7 | status: bit0 pending, bit1 overrun, bit2 index of the last completed buffer, bits [15:8] completion count |

In the status register, writing 1 to bit0 or bit1 clears that bit. Every register resets to zero. Lengths are in words, from 1 to 2^AW-1.

Top module: `pingpong_stream_writer`

## Requirements
- R1: A sample is taken only on a clock where s_valid and s_ready are both high. s_ready is low whenever neither ownership bit (arm register bits [1:0]) is set, and whenever the FIFO holds DEPTH entries.
- R2: Every accepted sample is written to memory exactly once, in arrival order, at most one write per clock. The write address is the active buffer's base plus a word offset, and the offset starts at 0 for each buffer.
- R3: A buffer completes on the write at offset length-1. Writing then moves to the other buffer (0 to 1, 1 to 0). A sample that follows on the very next clock goes to offset 0 of the new buffer. A length of 1 completes on every write.
- R4: With the buffer's park bit clear, completion clears that buffer's ownership bit. The writer waits on the buffer next in ring order until it is re-armed, even when the other buffer is owned. Waiting samples stay in the FIFO and are not lost.
- R5: With the buffer's park bit set, completion leaves its ownership bit set, and a continuous stream keeps alternating between both buffers with no register writes.
- R6: Every completion sets status bit0, stores the completed buffer index in status bit2, and increments the count in status bits [15:8]. irq equals status bit0 AND control bit0. Writing 1 to status bit0 clears it.
- R7: A completion while status bit0 is already set sets the sticky overrun flag, status bit1. Only writing 1 to status bit1 clears it.
- R8: When the active buffer is not owned but the other one is, the block still accepts exactly DEPTH samples into the FIFO, then drops s_ready.
- R9: Registers 0, 1, 2, 3, 4 and 6 read back what was written. All registers read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Stream sample valid |
| s_ready | output | 1 | Stream sample ready |
| s_data | input | DW | Stream sample |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| irq | output | 1 | Completion interrupt |

## Verification
The bench sweeps both buffer lengths over 1 to 3 in park mode with an unbroken stream, so every completion is followed at once by the next buffer's first sample. A writer that loses or misplaces that first word, or mishandles length 1, produces an address sequence that differs from the one the bench computes.

A non-park run lets both buffers complete without clearing the pending bit. Software-visible state then has to show the right last-buffer index, the count and the overrun flag; a design that drops the overrun or reports the wrong buffer fails here.

A FIFO-fill case arms only the buffer that is not next in ring order. A design that skips ahead writes too early, and one that sizes ready wrongly accepts other than DEPTH samples.

// File: rtl/pingpong_stream_writer.sv
module pingpong_stream_writer #(
  parameter int DW    = 16,
  parameter int AW    = 8,
  parameter int DEPTH = 4,
  parameter int CW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          irq
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PW:0] FULL = (PW+1)'(DEPTH);

  logic [DW-1:0] fmem [DEPTH];
  logic [PW-1:0] rp, wp;
  logic [PW:0]   fcnt;

  logic [AW-1:0] base0, base1, len0, len1, off;
  logic [1:0]    own, own_n, park;
  logic          cur, irq_en, pending, overrun, last_buf;
  logic [CW-1:0] cnt;

  wire push  = s_valid & s_ready;
  wire [AW-1:0] cur_base = cur ? base1 : base0;
  wire [AW-1:0] cur_len  = cur ? len1  : len0;
  wire done  = mem_we & (off == cur_len - 1'b1);

  wire w_ctrl = reg_we & (reg_addr == 3'd0);
  wire w_b0   = reg_we & (reg_addr == 3'd1);
  wire w_l0   = reg_we & (reg_addr == 3'd2);
  wire w_b1   = reg_we & (reg_addr == 3'd3);
  wire w_l1   = reg_we & (reg_addr == 3'd4);
  wire w_arm  = reg_we & (reg_addr == 3'd5);
  wire w_mode = reg_we & (reg_addr == 3'd6);
  wire w_stat = reg_we & (reg_addr == 3'd7);

  assign s_ready   = (fcnt != FULL) & (|own);
  assign mem_we    = (fcnt != '0) & own[cur];
  assign mem_addr  = cur_base + off;
  assign mem_wdata = fmem[rp];
  assign irq       = pending & irq_en;

  always_ff @(posedge clk) begin
    if (push) fmem[wp] <= s_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rp   <= '0;
      wp   <= '0;
      fcnt <= '0;
    end else begin
      if (push)   wp <= wp + PW'(1);
      if (mem_we) rp <= rp + PW'(1);
      fcnt <= fcnt + (PW+1)'(push) - (PW+1)'(mem_we);
    end
  end

  always_comb begin
    own_n = own;
    if (done && !park[cur]) own_n[cur] = 1'b0;
    if (w_arm) own_n = own_n | reg_wdata[1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cur <= 1'b0;
      off <= '0;
    end else if (done) begin
      cur <= ~cur;
      off <= '0;
    end else if (mem_we) begin
      off <= off + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_en <= 1'b0;
      base0  <= '0;
      base1  <= '0;
      len0   <= '0;
      len1   <= '0;
      own    <= '0;
      park   <= '0;
    end else begin
      if (w_ctrl) irq_en <= reg_wdata[0];
      if (w_b0)   base0  <= reg_wdata[AW-1:0];
      if (w_l0)   len0   <= reg_wdata[AW-1:0];
      if (w_b1)   base1  <= reg_wdata[AW-1:0];
      if (w_l1)   len1   <= reg_wdata[AW-1:0];
      if (w_mode) park   <= reg_wdata[1:0];
      own <= own_n;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending  <= 1'b0;
      overrun  <= 1'b0;
      last_buf <= 1'b0;
      cnt      <= '0;
    end else begin
      pending <= done | (pending & ~(w_stat & reg_wdata[0]));
      overrun <= (done & pending) | (overrun & ~(w_stat & reg_wdata[1]));
      if (done) begin
        last_buf <= cur;
        cnt      <= cnt + 1'b1;
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      3'd0: reg_rdata[0]      = irq_en;
      3'd1: reg_rdata[AW-1:0] = base0;
      3'd2: reg_rdata[AW-1:0] = len0;
      3'd3: reg_rdata[AW-1:0] = base1;
      3'd4: reg_rdata[AW-1:0] = len1;
      3'd5: reg_rdata[1:0]    = own;
      3'd6: reg_rdata[1:0]    = park;
      default: begin
        reg_rdata[0]      = pending;
        reg_rdata[1]      = overrun;
        reg_rdata[2]      = last_buf;
        reg_rdata[8 +: CW] = cnt;
      end
    endcase
  end
endmodule

// File: rtl/pingpong_stream_writer_chk.sv
module pingpong_stream_writer_chk #(
  parameter int AW    = 8,
  parameter int DEPTH = 4,
  parameter int CW    = 8,
  parameter int FW    = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          s_valid,
  input logic          s_ready,
  input logic          mem_we,
  input logic          done,
  input logic          cur,
  input logic [AW-1:0] off,
  input logic [1:0]    own,
  input logic [1:0]    park,
  input logic          pending,
  input logic          overrun,
  input logic [CW-1:0] cnt,
  input logic [FW-1:0] fcnt
);
  AST_IDLE_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (own == 2'b00) |-> !s_ready);  // R1
  AST_FIFO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fcnt <= FW'(DEPTH));  // R8
  AST_FIFO_ACCOUNT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> fcnt == FW'($past(fcnt) + FW'($past(s_valid && s_ready)) - FW'($past(mem_we))));  // R2
  AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && !done) |=> (off == AW'($past(off) + 1'b1)) && (cur == $past(cur)));  // R2
  AST_RING_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (cur != $past(cur)) && (off == '0));  // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we |=> $stable(off) && $stable(cur));  // R4
  AST_PARK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (done && park[cur]) |=> own[$past(cur)]);  // R5
  AST_PENDING_SET: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> pending);  // R6
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> cnt == CW'($past(cnt) + 1'b1));  // R6
  AST_OVERRUN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (done && pending) |=> overrun);  // R7
endmodule

bind pingpong_stream_writer pingpong_stream_writer_chk #(
  .AW(AW), .DEPTH(DEPTH), .CW(CW), .FW(PW+1)
) u_chk (
  .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
  .mem_we(mem_we), .done(done), .cur(cur), .off(off), .own(own),
  .park(park), .pending(pending), .overrun(overrun), .cnt(cnt), .fcnt(fcnt)
);

// File: tb/tb_pingpong_stream_writer.sv
module tb_pingpong_stream_writer;
  localparam int DW = 16, AW = 8, DEPTH = 4, CW = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic s_valid = 1'b0, s_ready;
  logic [DW-1:0] s_data = '0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic mem_we, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;

  pingpong_stream_writer #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .CW(CW)) dut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .irq(irq)
  );

  always #5 clk = ~clk;

  int nchk = 0, nfail = 0, nlog = 0, cyc = 0;
  int log_a [1024];
  int log_d [1024];

  always @(negedge clk) begin
    if (rst_n && mem_we && nlog < 1024) begin
      log_a[nlog] = int'(mem_addr);
      log_d[nlog] = int'(mem_wdata);
      nlog++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = 32'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 3'(a);
    #1;
    v = int'(reg_rdata);
  endtask

  task automatic send(input int d);
    int g = 0;
    s_valid = 1'b1; s_data = DW'(d);
    while (!s_ready && g < 1000) begin
      @(negedge clk); g++;
    end
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; s_valid = 1'b0; reg_we = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    nlog = 0;
  endtask

  initial begin
    int v, acc, n0, exp_a, c, o, comp;
    int base [2];
    int len [2];

    do_reset();
    rd(7, v); chk(v == 0, "R9 status reset", v, 0);
    rd(5, v); chk(v == 0, "R9 arm reset", v, 0);
    chk(s_ready == 1'b0, "R1 ready low after reset", int'(s_ready), 0);
    chk(irq == 1'b0, "R6 irq low after reset", int'(irq), 0);

    wr(0, 1); wr(1, 10); wr(2, 3); wr(3, 40); wr(4, 5); wr(6, 0);
    rd(0, v); chk(v == 1, "R9 ctrl readback", v, 1);
    rd(1, v); chk(v == 10, "R9 base0 readback", v, 10);
    rd(2, v); chk(v == 3, "R9 len0 readback", v, 3);
    rd(3, v); chk(v == 40, "R9 base1 readback", v, 40);
    rd(4, v); chk(v == 5, "R9 len1 readback", v, 5);
    wr(6, 3); rd(6, v); chk(v == 3, "R9 mode readback", v, 3);
    wr(6, 0);

    // non-park: both buffers complete, pending never cleared
    wr(5, 3);
    for (int i = 0; i < 8; i++) send(256 + i);
    s_valid = 1'b0;
    repeat (8) @(negedge clk);
    chk(nlog == 8, "R2 write count", nlog, 8);
    for (int i = 0; i < 8; i++) begin
      exp_a = (i < 3) ? 10 + i : 40 + i - 3;
      chk(log_a[i] == exp_a, "R3 nonpark address", log_a[i], exp_a);
      chk(log_d[i] == 256 + i, "R2 nonpark data order", log_d[i], 256 + i);
    end
    rd(7, v); chk(v == 'h207, "R7 status after two completions", v, 'h207);
    rd(5, v); chk(v == 0, "R4 ownership cleared", v, 0);
    chk(irq == 1'b1, "R6 irq asserted", int'(irq), 1);

    // idle: nothing owned
    s_valid = 1'b1; s_data = 16'hBEEF;
    repeat (5) begin
      @(negedge clk);
      chk(s_ready == 1'b0, "R1 ready low when idle", int'(s_ready), 0);
    end
    s_valid = 1'b0;
    chk(nlog == 8, "R1 no write when idle", nlog, 8);

    wr(7, 3);
    rd(7, v); chk(v == 'h204, "R6 R7 W1C clears flags", v, 'h204);
    chk(irq == 1'b0, "R6 irq cleared", int'(irq), 0);

    // ring order strict: arm only buffer 1 while buffer 0 is next
    wr(5, 2);
    acc = 0;
    for (int k = 0; k < 10; k++) begin
      s_valid = 1'b1; s_data = DW'(512 + acc);
      if (s_ready) acc++;
      @(negedge clk);
    end
    s_valid = 1'b0;
    chk(acc == DEPTH, "R8 FIFO accepts DEPTH", acc, DEPTH);
    chk(nlog == 8, "R4 no write to out-of-order buffer", nlog, 8);
    wr(5, 1);
    repeat (10) @(negedge clk);
    chk(nlog == 12, "R4 drain after rearm", nlog, 12);
    for (int i = 0; i < 4; i++) begin
      exp_a = (i < 3) ? 10 + i : 40;
      chk(log_a[8 + i] == exp_a, "R4 drain address", log_a[8 + i], exp_a);
      chk(log_d[8 + i] == 512 + i, "R4 drain data", log_d[8 + i], 512 + i);
    end
    rd(5, v); chk(v == 2, "R4 buffer0 released buffer1 kept", v, 2);
    rd(7, v); chk(v == 'h301, "R6 status after third completion", v, 'h301);

    // park sweep over lengths, interrupt disabled
    for (int l0 = 1; l0 <= 3; l0++) begin
      for (int l1 = 1; l1 <= 3; l1++) begin
        do_reset();
        base[0] = 100; base[1] = 200; len[0] = l0; len[1] = l1;
        wr(1, 100); wr(2, l0); wr(3, 200); wr(4, l1); wr(6, 3); wr(5, 3);
        n0 = 2 * (l0 + l1) + 1;
        for (int i = 0; i < n0; i++) send(1000 + i);
        s_valid = 1'b0;
        repeat (8) @(negedge clk);
        chk(nlog == n0, "R5 park write count", nlog, n0);
        c = 0; o = 0; comp = 0;
        for (int i = 0; i < n0; i++) begin
          exp_a = base[c] + o;
          chk(log_a[i] == exp_a, "R3 R5 park address", log_a[i], exp_a);
          chk(log_d[i] == 1000 + i, "R2 park data", log_d[i], 1000 + i);
          if (o == len[c] - 1) begin o = 0; c ^= 1; comp++; end
          else o++;
        end
        rd(5, v); chk(v == 3, "R5 ownership kept", v, 3);
        rd(7, v); chk(((v >> 8) & 255) == comp, "R6 completion count", (v >> 8) & 255, comp);
        chk((v & 1) == 1, "R6 pending set", v & 1, 1);
        chk(irq == 1'b0, "R6 irq masked", int'(irq), 0);
      end
    end

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule